// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block sits on the controller side of a graphics DRAM interface. It moves the memory into and out of self refresh and power down. It drives the clock-enable lines and a two-bit command code. Pulsed requests start each move. When a move out of a low-power state is finished, the block raises `ready` to signal that normal traffic may resume. A separate flag, `rd_ok`, also waits for the delay-locked loop to relock after self refresh, and only then are read or termination-disable commands allowed.

Self refresh is entered with an auto-refresh command while clock enable is low in the same cycle. Power down is entered with clock enable low and a NOP. Each exit raises clock enable and then holds the bus at NOP for a blackout window of its own length (`T_XSC` or `T_XPN`). Refresh cannot happen inside power down. If `refresh_due` is seen while powered down, the sequencer leaves power down, waits out the blackout, issues an auto refresh and goes back into power down without any further request. All devices on the shared command/address bus get the same clock enable, so they always move together.

States: `ST_ACTIVE`, `ST_SR_ENTRY`, `ST_SELF_REF`, `ST_SR_EXIT`, `ST_PD_REFRESH`, `ST_PD_ENTRY`, `ST_POWER_DOWN`, `ST_PD_EXIT`. Transitions:
- ACTIVE→SR_ENTRY on a self-refresh request.
- ACTIVE→PD_REFRESH on a power-down request with refresh due.
- ACTIVE→PD_ENTRY on a power-down request with no refresh due.
- SR_ENTRY→SELF_REF always.
- SELF_REF→SR_EXIT on an exit request.
- SR_EXIT→ACTIVE when the blackout ends.
- PD_REFRESH→PD_ENTRY always.
- PD_ENTRY→POWER_DOWN always.
- POWER_DOWN→PD_EXIT on an exit request or on refresh due.
- PD_EXIT→PD_REFRESH when the blackout ends and the exit was caused by refresh.
- PD_EXIT→ACTIVE when the blackout ends otherwise.

Top module: `lpm_seq`

## Requirements
- R1: While reset is applied and afterwards, every `cke` bit is 1, `cmd` is DESEL (01), `ready` is 1 and `rd_ok` is 1.
- R2: A self-refresh request seen in ACTIVE gives, one cycle after that edge, one cycle of `cke`=0 with `cmd`=AREF (10). After that, `cke` stays 0 with `cmd`=NOP (00) and `ready`=0 until an exit request.
- R3: A self-refresh exit request gives exactly `T_XSC` cycles of `cke`=1, `cmd`=NOP, `ready`=0. These are followed by `cmd`=DESEL with `ready`=1.
- R4: After a self-refresh exit, `rd_ok` stays 0 for the first `T_DLL` cycles, counted from the first cycle with `cke` high. It rises after that, and never while `ready` is 0.
- R5: A power-down request with `refresh_due`=0 gives `cke`=0 with `cmd`=NOP and `ready`=0 from the next cycle onward.
- R6: A power-down request with `refresh_due`=1 first gives one cycle of `cke`=1 with `cmd`=AREF. Then `cke`=0 with NOP follows.
- R7: A power-down exit request gives exactly `T_XPN` cycles of `cke`=1, NOP and `ready`=0, followed by DESEL with `ready`=1. `rd_ok` follows `ready` when no relock is pending.
- R8: When `refresh_due` is seen in power down, the block leaves power down for `T_XPN` NOP cycles. It then issues one AREF with `cke`=1 and returns to `cke`=0 NOP with no new request.
- R9: A power-down exit request made during the blackout of an R8 refresh exit cancels the re-entry. The block ends in ACTIVE.
- R10: An entry request that arrives outside ACTIVE, for example during a blackout, is held. It is acted on in the first cycle back in ACTIVE.
- R11: If self-refresh and power-down requests arrive together, self refresh is entered and the power-down request is discarded.
- R12: Exit requests have no effect unless the block is in SELF_REF or POWER_DOWN (or, for R9, in the power-down blackout).
- R13: All `cke` bits carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_enter_req | input | 1 | Pulse: request self-refresh entry |
| sr_exit_req | input | 1 | Pulse: request self-refresh exit |
| pd_enter_req | input | 1 | Pulse: request power-down entry |
| pd_exit_req | input | 1 | Pulse: request power-down exit |
| refresh_due | input | 1 | A refresh must be performed |
| cke | output | NDEV | Clock enable, one per device, all equal |
| cmd | output | 2 | Command code: 00 NOP, 01 DESEL, 10 AREF, 11 RD (never driven here) |
| ready | output | 1 | Normal commands may be issued |
| rd_ok | output | 1 | Read and termination-disable commands may be issued |

## Verification
The bench runs self refresh with several residence lengths. For each exit it sweeps every cycle up to past the relock count. This separates an off-by-one in the `T_XSC` blackout from one in the `T_DLL` relock. Power down is tried with and without refresh due at entry, which shows whether the extra AREF is placed correctly. The refresh-driven exit is run both plain and with an exit request inside its blackout, which shows whether automatic re-entry happens and whether it can be cancelled. Requests are also given while in the wrong state, together with each other, and during a blackout, to check holding, priority and dropping.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_DESEL = 2'b01,
        CMD_AREF  = 2'b10,
        CMD_RD    = 2'b11
    } cmd_t;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_SR_ENTRY,
        ST_SELF_REF,
        ST_SR_EXIT,
        ST_PD_REFRESH,
        ST_PD_ENTRY,
        ST_POWER_DOWN,
        ST_PD_EXIT
    } lpm_state_t;

endpackage

// File: rtl/lpm_timer.sv
module lpm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int NDEV  = 2,
    parameter int T_XSC = 200,
    parameter int T_XPN = 4,
    parameter int T_DLL = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_enter_req,
    input  logic            sr_exit_req,
    input  logic            pd_enter_req,
    input  logic            pd_exit_req,
    input  logic            refresh_due,
    output logic [NDEV-1:0] cke,
    output logic [1:0]      cmd,
    output logic            ready,
    output logic            rd_ok
);

    localparam int BLK_MAX = (T_XSC > T_XPN) ? T_XSC : T_XPN;
    localparam int BW      = $clog2(BLK_MAX + 1);
    localparam int DW      = $clog2(T_DLL + 1);

    lpm_state_t state, nxt;
    logic       pend_sr, pend_pd, resume, resume_nxt;
    logic       take_entry, ld_blk, ld_dll;
    logic [BW-1:0] blk_val, blk_cnt;
    logic [DW-1:0] dll_cnt;
    logic       want_sr, want_pd, blk_last, dll_zero;
    logic       cke_one;
    cmd_t       cmd_q;

    assign want_sr  = pend_sr | sr_enter_req;
    assign want_pd  = pend_pd | pd_enter_req;
    assign blk_last = (blk_cnt == BW'(1));
    assign dll_zero = (dll_cnt == '0);

    lpm_timer #(.W(BW)) u_blk (
        .clk(clk), .rst_n(rst_n), .load(ld_blk), .load_val(blk_val), .cnt(blk_cnt)
    );

    lpm_timer #(.W(DW)) u_dll (
        .clk(clk), .rst_n(rst_n), .load(ld_dll), .load_val(DW'(T_DLL)), .cnt(dll_cnt)
    );

    // next-state logic
    always_comb begin
        nxt        = state;
        take_entry = 1'b0;
        ld_blk     = 1'b0;
        ld_dll     = 1'b0;
        blk_val    = '0;
        resume_nxt = resume;
        unique case (state)
            ST_ACTIVE: begin
                if (want_sr) begin
                    nxt        = ST_SR_ENTRY;
                    take_entry = 1'b1;
                end else if (want_pd) begin
                    nxt        = refresh_due ? ST_PD_REFRESH : ST_PD_ENTRY;
                    take_entry = 1'b1;
                end
            end
            ST_SR_ENTRY:   nxt = ST_SELF_REF;
            ST_SELF_REF: begin
                if (sr_exit_req) begin
                    nxt     = ST_SR_EXIT;
                    ld_blk  = 1'b1;
                    blk_val = BW'(T_XSC);
                    ld_dll  = 1'b1;
                end
            end
            ST_SR_EXIT: begin
                if (blk_last) nxt = ST_ACTIVE;
            end
            ST_PD_REFRESH: nxt = ST_PD_ENTRY;
            ST_PD_ENTRY:   nxt = ST_POWER_DOWN;
            ST_POWER_DOWN: begin
                if (pd_exit_req || refresh_due) begin
                    nxt        = ST_PD_EXIT;
                    ld_blk     = 1'b1;
                    blk_val    = BW'(T_XPN);
                    resume_nxt = !pd_exit_req;
                end
            end
            ST_PD_EXIT: begin
                if (pd_exit_req) resume_nxt = 1'b0;
                if (blk_last) nxt = resume_nxt ? ST_PD_REFRESH : ST_ACTIVE;
            end
            default: nxt = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ACTIVE;
            pend_sr <= 1'b0;
            pend_pd <= 1'b0;
            resume  <= 1'b0;
        end else begin
            state   <= nxt;
            pend_sr <= take_entry ? 1'b0 : want_sr;
            pend_pd <= take_entry ? 1'b0 : want_pd;
            resume  <= resume_nxt;
        end
    end

    // output decode
    always_comb begin
        cke_one = 1'b1;
        cmd_q   = CMD_NOP;
        ready   = 1'b0;
        unique case (state)
            ST_ACTIVE:     begin cmd_q = CMD_DESEL; ready = 1'b1; end
            ST_SR_ENTRY:   begin cke_one = 1'b0; cmd_q = CMD_AREF; end
            ST_SELF_REF:   cke_one = 1'b0;
            ST_SR_EXIT:    cmd_q = CMD_NOP;
            ST_PD_REFRESH: cmd_q = CMD_AREF;
            ST_PD_ENTRY:   cke_one = 1'b0;
            ST_POWER_DOWN: cke_one = 1'b0;
            ST_PD_EXIT:    cmd_q = CMD_NOP;
            default:       cmd_q = CMD_DESEL;
        endcase
    end

    assign cke   = {NDEV{cke_one}};
    assign cmd   = cmd_q;
    assign rd_ok = ready && dll_zero;

    // R2
    sr_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke[0] && cmd == CMD_AREF) |=> !cke[0]);

    // R3
    exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke[0]) |-> (cmd == CMD_NOP && !ready));

    // R4
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> ready);

    // R5
    low_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke[0] |-> !ready);

    // R7
    ready_after_blackout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> blk_cnt == '0);

    // R6
    fall_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke[0]) |-> (cmd == CMD_AREF || cmd == CMD_NOP));

endmodule

// File: tb/sim_lpm_seq.sv
module sim_lpm_seq;

    localparam int NDEV  = 2;
    localparam int T_XSC = 5;
    localparam int T_XPN = 3;
    localparam int T_DLL = 12;

    localparam logic [1:0] NOP   = 2'b00;
    localparam logic [1:0] DESEL = 2'b01;
    localparam logic [1:0] AREF  = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_enter_req = 1'b0, sr_exit_req = 1'b0;
    logic pd_enter_req = 1'b0, pd_exit_req = 1'b0;
    logic refresh_due = 1'b0;
    logic [NDEV-1:0] cke;
    logic [1:0] cmd;
    logic ready, rd_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lpm_seq #(.NDEV(NDEV), .T_XSC(T_XSC), .T_XPN(T_XPN), .T_DLL(T_DLL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
        .pd_enter_req(pd_enter_req), .pd_exit_req(pd_exit_req),
        .refresh_due(refresh_due),
        .cke(cke), .cmd(cmd), .ready(ready), .rd_ok(rd_ok)
    );

    task automatic expect_out(input string req, input bit e_cke, input logic [1:0] e_cmd,
                              input bit e_rdy, input int e_rdok);
        n_tests++;
        if (cke != {NDEV{e_cke}} || cmd != e_cmd || ready != e_rdy ||
            (e_rdok >= 0 && rd_ok != e_rdok[0])) begin
            n_fail++;
            $display("FAIL %s: cke=%b cmd=%b ready=%b rd_ok=%b expected cke=%b cmd=%b ready=%b rd_ok=%0d",
                     req, cke, cmd, ready, rd_ok, {NDEV{e_cke}}, e_cmd, e_rdy, e_rdok);
        end
        n_tests++;
        if (cke != {NDEV{cke[0]}}) begin
            n_fail++;
            $display("FAIL R13: cke=%b expected all bits equal", cke);
        end
    endtask

    // one-cycle request pulse ending on a negedge (the sample point after one posedge)
    task automatic pulse(input bit a, input bit b, input bit c, input bit d);
        @(negedge clk);
        sr_enter_req = a; sr_exit_req = b; pd_enter_req = c; pd_exit_req = d;
        @(negedge clk);
        sr_enter_req = 0; sr_exit_req = 0; pd_enter_req = 0; pd_exit_req = 0;
    endtask

    task automatic sr_exit_sweep(input string req);
        pulse(0, 1, 0, 0);
        for (int i = 0; i <= T_DLL + 1; i++) begin
            if (i > 0) @(negedge clk);
            expect_out(req, 1'b1, (i < T_XSC) ? NOP : DESEL, i >= T_XSC, (i >= T_DLL) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b1, DESEL, 1'b1, 1);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1'b1, DESEL, 1'b1, 1);

        // R2/R3/R4 sweep over self-refresh residence length
        for (int n = 0; n < 3; n++) begin
            pulse(1, 0, 0, 0);
            expect_out("R2 entry", 1'b0, AREF, 1'b0, -1);
            for (int k = 0; k <= n; k++) begin
                @(negedge clk);
                expect_out("R2 resident", 1'b0, NOP, 1'b0, -1);
            end
            sr_exit_sweep("R3/R4 exit");
        end

        // R12: exit requests in ACTIVE and a power-down exit in self refresh are ignored
        pulse(0, 1, 0, 1);
        expect_out("R12 active", 1'b1, DESEL, 1'b1, 1);
        @(negedge clk);
        expect_out("R12 active hold", 1'b1, DESEL, 1'b1, 1);
        pulse(1, 0, 0, 0);
        @(negedge clk);
        expect_out("R12 in self refresh", 1'b0, NOP, 1'b0, -1);
        pulse(0, 0, 0, 1);
        expect_out("R12 pd exit ignored", 1'b0, NOP, 1'b0, -1);
        @(negedge clk);
        expect_out("R12 still self refresh", 1'b0, NOP, 1'b0, -1);

        // R10: power-down request during the self-refresh blackout is held
        pulse(0, 1, 0, 0);
        expect_out("R10 blackout", 1'b1, NOP, 1'b0, 0);
        pd_enter_req = 1'b1;
        @(negedge clk);
        pd_enter_req = 1'b0;
        for (int i = 1; i < T_XSC; i++) begin
            if (i > 1) @(negedge clk);
            expect_out("R10 blackout", 1'b1, NOP, 1'b0, 0);
        end
        @(negedge clk);
        expect_out("R10 active once", 1'b1, DESEL, 1'b1, 0);
        @(negedge clk);
        expect_out("R10 held request taken", 1'b0, NOP, 1'b0, 0);
        @(negedge clk);
        expect_out("R10 power down", 1'b0, NOP, 1'b0, 0);
        pulse(0, 0, 0, 1);
        for (int i = 0; i < T_XPN; i++) begin
            if (i > 0) @(negedge clk);
            expect_out("R7 blackout", 1'b1, NOP, 1'b0, 0);
        end
        repeat (T_DLL) @(negedge clk);
        expect_out("R4 relock done", 1'b1, DESEL, 1'b1, 1);

        // R5/R7: power down without refresh due
        pulse(0, 0, 1, 0);
        expect_out("R5 entry", 1'b0, NOP, 1'b0, -1);
        @(negedge clk);
        expect_out("R5 resident", 1'b0, NOP, 1'b0, -1);
        pulse(0, 0, 0, 1);
        for (int i = 0; i <= T_XPN + 1; i++) begin
            if (i > 0) @(negedge clk);
            expect_out("R7 exit", 1'b1, (i < T_XPN) ? NOP : DESEL, i >= T_XPN, (i >= T_XPN) ? 1 : 0);
        end

        // R6: power down with refresh due
        @(negedge clk);
        refresh_due = 1'b1; pd_enter_req = 1'b1;
        @(negedge clk);
        refresh_due = 1'b0; pd_enter_req = 1'b0;
        expect_out("R6 refresh first", 1'b1, AREF, 1'b0, -1);
        @(negedge clk);
        expect_out("R6 then entry", 1'b0, NOP, 1'b0, -1);
        @(negedge clk);
        expect_out("R6 resident", 1'b0, NOP, 1'b0, -1);

        // R8: refresh due while powered down
        @(negedge clk);
        refresh_due = 1'b1;
        @(negedge clk);
        refresh_due = 1'b0;
        for (int i = 0; i < T_XPN; i++) begin
            if (i > 0) @(negedge clk);
            expect_out("R8 blackout", 1'b1, NOP, 1'b0, 0);
        end
        @(negedge clk);
        expect_out("R8 refresh", 1'b1, AREF, 1'b0, 0);
        @(negedge clk);
        expect_out("R8 re-entry", 1'b0, NOP, 1'b0, 0);
        @(negedge clk);
        expect_out("R8 resident", 1'b0, NOP, 1'b0, 0);

        // R9: exit request inside the refresh blackout cancels re-entry
        @(negedge clk);
        refresh_due = 1'b1;
        @(negedge clk);
        refresh_due = 1'b0;
        expect_out("R9 blackout", 1'b1, NOP, 1'b0, 0);
        pd_exit_req = 1'b1;
        @(negedge clk);
        pd_exit_req = 1'b0;
        for (int i = 1; i <= T_XPN + 1; i++) begin
            if (i > 1) @(negedge clk);
            expect_out("R9 cancel", 1'b1, (i < T_XPN) ? NOP : DESEL, i >= T_XPN, (i >= T_XPN) ? 1 : 0);
        end

        // R11: simultaneous requests, self refresh wins, power down dropped
        pulse(1, 0, 1, 0);
        expect_out("R11 self refresh wins", 1'b0, AREF, 1'b0, -1);
        @(negedge clk);
        sr_exit_sweep("R11 exit");
        @(negedge clk);
        expect_out("R11 pd discarded", 1'b1, DESEL, 1'b1, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule